// File: doc/BRIEF.md
# General Purpose I/O Port with Output Latch Readback

This block is one general purpose I/O port of parameterised width (eight pins by default). Software reaches it through a small register bus with separate write and read strobes and a two-bit address. It keeps three registers:

- a direction register that decides which pins are driven;
- an output data latch that holds the value to drive;
- a pin-level view, read through a synchronizer.

The block presents a tri-state output value and output enable for every pin, and samples the pin inputs.

Two addresses write the same output latch: the pin-level address and the latch address. They differ only when read. A latch read returns the value the port is trying to drive. A pin read returns the level actually present on the pins. Read-modify-write sequences should therefore read the latch, so that a pin held low by an external load cannot corrupt the bits written back.

Each pin can be handed to a peripheral through a per-pin enable. While that enable is high, the peripheral's own value and output enable drive the pin. The pin-level read path keeps showing the real pin level. Reset leaves every pin undriven with the latch cleared.

Top module: `gpio_port`

## Requirements
- R1: The state after reset is: every direction bit at 1, latch all 0, `pin_oe` all 0, `pin_out` all 0 and `rdata` 0.
- R2: A write (`wr_en`=1) to address 0 or address 1 loads `wdata` into the output latch at that clock edge. A later latch read returns the value written.
- R3: A read of address 1 returns the output latch contents, whatever level is on `pin_in`.
- R4: A read of address 0 returns `pin_in` after a two-flop synchronizer. A level applied before clock edge E is returned by a read whose strobe is sampled at edge E+2 or later. `rdata` changes only at an edge where `rd_en` is 1; at any other edge it holds its value.
- R5: A write to address 2 loads the direction register, and a read of address 2 returns it.
- R6: For a pin without peripheral enable, the outputs are registered one cycle after the register state. `pin_oe` is the inverse of the direction bit (1 = input, 0 = driven) and `pin_out` is the latch bit.
- R7: For a pin whose `per_en` bit is 1, the next edge takes `pin_out` from `per_out` and `pin_oe` from `per_oe`. The latch and direction bits are ignored for that pin.
- R8: While a pin is under peripheral control, a read of address 0 still returns that pin's input level.
- R9: A read of address 3 returns 0. A write to address 3 changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and port clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; loads `rdata` |
| addr | input | 2 | Register select: 0 pin level, 1 latch, 2 direction |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Levels sampled from the pins |
| pin_out | output | WIDTH | Value driven onto each pin |
| pin_oe | output | WIDTH | Output driver enable per pin, 1 = drive |
| per_en | input | WIDTH | Per-pin peripheral takeover |
| per_out | input | WIDTH | Peripheral output value |
| per_oe | input | WIDTH | Peripheral output enable |

## Verification
The assertions check on every cycle how the registered pin outputs follow the direction, the latch and the peripheral override. They also check that the latch tracks writes, that each read address returns its source, and that `rdata` holds when no read strobe is present. Some behaviour can only be shown by the bench's scenarios, because it spans several transactions or depends on the external pin. These are the reset state, the synchronizer's two-cycle delay from pin change to readable value, a latch read that differs from a pin level pulled elsewhere, and a write to the unused address that leaves both registers untouched. The bench sweeps all 256 latch, direction and pin values, together with a set of override masks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q
);
  logic lat_hit;
  logic dir_hit;

  // Both the pin address and the latch address land in the output latch.
  assign lat_hit = wr_en && (addr == REG_PIN || addr == REG_LAT);
  assign dir_hit = wr_en && (addr == REG_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_hit) lat_q <= wdata;
      if (dir_hit) dir_q <= wdata;
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == REG_PIN || addr == REG_LAT)) |=> (lat_q == $past(wdata))); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_DIR) |=> (dir_q == $past(wdata))); // R5

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q))); // R9

  AST_RESET_REGS: assert property (@(posedge clk)
    $past(rst) |-> (lat_q == '0 && dir_q == '1)); // R1
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= pin_in;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign pin_sync = chain[LAST];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R4
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] per_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (per_en[i]) begin
        pin_out[i] <= per_out[i];
        pin_oe[i]  <= per_oe[i];
      end else begin
        pin_out[i] <= lat_q[i];
        pin_oe[i]  <= ~dir_q[i];
      end
    end
  end

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & ~$past(per_en)) == (~$past(dir_q) & ~$past(per_en)))); // R6

  AST_OUT_FROM_LATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out & ~$past(per_en)) == ($past(lat_q) & ~$past(per_en)))); // R6

  AST_PERIPH_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_out & $past(per_en)) == ($past(per_out) & $past(per_en))) &&
              ((pin_oe & $past(per_en)) == ($past(per_oe) & $past(per_en))))); // R7

  AST_RESET_PINS: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0)); // R1
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  per_en,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_oe
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_mux;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .lat_q (lat_q),
    .dir_q (dir_q)
  );

  gpio_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_pinmux #(.WIDTH(WIDTH)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .lat_q   (lat_q),
    .dir_q   (dir_q),
    .per_en  (per_en),
    .per_out (per_out),
    .per_oe  (per_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    case (addr)
      REG_PIN: rd_mux = pin_sync;
      REG_LAT: rd_mux = lat_q;
      REG_DIR: rd_mux = dir_q;
      default: rd_mux = '0;
    endcase
  end

  // The read strobe opens the capture stage; between reads the value holds.
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R4

  AST_PIN_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_PIN) |=> (rdata == $past(pin_sync))); // R8

  AST_LATCH_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_LAT) |=> (rdata == $past(lat_q))); // R3

  AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_DIR) |=> (rdata == $past(dir_q))); // R5

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |=> (rdata == '0)); // R9
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, rd_en;
  logic [1:0]   addr;
  logic [W-1:0] wdata, rdata, pin_in, pin_out, pin_oe, per_en, per_out, per_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .per_en(per_en), .per_out(per_out), .per_oe(per_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    pin_in = 8'hA5; per_en = 0; per_out = 0; per_oe = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    bus_read(2'd2, r); check("R1 dir", r, 8'hFF);
    bus_read(2'd1, r); check("R1 latch", r, 8'h00);

    // R5 direction sweep with R6 output enable
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd2, v[W-1:0]);
      bus_read(2'd2, r);
      check("R5 dir readback", r, v[W-1:0]);
      check("R6 pin_oe", pin_oe, ~v[W-1:0]);
    end
    bus_write(2'd2, 8'h00);

    // R2/R3/R6 latch sweep, alternating write address, pins pulled opposite
    for (int v = 0; v < 256; v++) begin
      pin_in = ~v[W-1:0];
      bus_write((v % 2 == 0) ? 2'd0 : 2'd1, v[W-1:0]);
      bus_read(2'd1, r);
      check("R2 latch write", r, v[W-1:0]);
      check("R3 latch not pin", r, v[W-1:0]);
      check("R6 pin_out", pin_out, v[W-1:0]);
    end

    // R4 pin read sweep through synchronizer
    for (int v = 0; v < 256; v++) begin
      pin_in = v[W-1:0];
      repeat (2) @(negedge clk);
      bus_read(2'd0, r);
      check("R4 pin read", r, v[W-1:0]);
    end

    // R4 synchronizer latency: too-early read sees old level
    pin_in = 8'h00; repeat (3) @(negedge clk);
    pin_in = 8'h3C; @(negedge clk);
    bus_read(2'd0, r); check("R4 early read", r, 8'h00);
    bus_read(2'd0, r); check("R4 settled read", r, 8'h3C);

    // R4 hold without strobe
    pin_in = 8'hC3; repeat (4) @(negedge clk);
    check("R4 rdata hold", rdata, 8'h3C);

    // R7/R8 peripheral override over several masks
    bus_write(2'd1, 8'h5A);
    bus_write(2'd2, 8'h0F);
    for (int m = 0; m < 16; m++) begin
      logic [W-1:0] em, eo, ee;
      em = W'(m * 8'h1D) ^ 8'h96;
      per_en = em; per_out = ~em ^ 8'h33; per_oe = W'(m * 8'h47);
      pin_in = W'(m * 8'h2B);
      @(negedge clk);
      eo = (em & per_out) | (~em & 8'h5A);
      ee = (em & per_oe)  | (~em & ~8'hF0 & 8'h0F) | (~em & ~8'h0F & 8'hF0 & 8'h00);
      ee = (em & per_oe) | (~em & ~8'h0F);
      check("R7 pin_out", pin_out, eo);
      check("R7 pin_oe", pin_oe, ee);
      repeat (2) @(negedge clk);
      bus_read(2'd0, r); check("R8 pin read under override", r, W'(m * 8'h2B));
    end
    per_en = 0;

    // R9 unused address
    bus_write(2'd3, 8'hE7);
    bus_read(2'd1, r); check("R9 latch untouched", r, 8'h5A);
    bus_read(2'd2, r); check("R9 dir untouched", r, 8'h0F);
    bus_read(2'd3, r); check("R9 read zero", r, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule